// File: doc/BRIEF.md
# Audio Master Clock Divider

This block produces the bit clock and the frame clock that an audio converter drives when it is the clock master of its serial link. It runs entirely from the master clock and is told two things: the speed class (single, double or quad rate) and whether the master clock is the slow or the fast multiple of the frame rate for that class. From these it picks how many master-clock cycles make one frame. Each frame carries 64 bit-clock periods, split evenly between the left half (frame clock low) and the right half (frame clock high). A one-cycle pulse in the master-clock domain marks the first cycle of every frame, so the data path can load its next sample pair.

The settings are sampled once when the block leaves reset and again only at each frame boundary, so a change in the middle of a frame never produces a short frame or a short bit. At the slow quad-rate multiple (64 master clocks per frame) the bit clock has the master clock's own rate. That setting is only legal when the converter is the master. When it is selected in slave mode, or when the unused speed code is selected, the block raises an error flag that stays set until reset and stops all clock output.

Top module: `audio_mclk_div`

## Requirements
- R1: While `rst_ni` is low, `lrck_o`, `sclk_o`, `frame_start_o` and `err_o` are all 0.
- R2: Frame length in master-clock cycles depends on `speed_i` (2'b00 single, 2'b01 double, 2'b10 quad) and `fast_i`. Single rate gives 256 cycles, or 512 with `fast_i`=1. Double rate gives 128, or 256 with `fast_i`=1. Quad rate gives 64, or 128 with `fast_i`=1.
- R3: Every frame holds exactly 64 `sclk_o` periods. Within each bit period `sclk_o` is low for the first half and high for the second half. At 64 cycles per frame, `sclk_o` is low while the master clock is high and high while it is low.
- R4: `lrck_o` is low for the first half of each frame (left channel) and high for the second half. The first master-clock rising edge after reset is released starts a frame, beginning with the left half.
- R5: `frame_start_o` is high for exactly the first master-clock cycle of each frame and low otherwise.
- R6: `speed_i`, `fast_i` and `master_i` are sampled only at the edge that starts a frame. A change in the middle of a frame leaves the current frame unchanged, and the new length applies from the next frame.
- R7: If the settings sampled at a frame start are quad rate with `fast_i`=0 and `master_i`=0, `err_o` goes to 1 and `lrck_o`, `sclk_o` and `frame_start_o` stay 0. This continues until the next reset, even after the inputs become legal.
- R8: If the sampled `speed_i` is 2'b11, the same error behaviour as R7 applies.
- R9: Quad rate with `fast_i`=0 and `master_i`=1 runs normally with `err_o` held at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk_i | input | 1 | Master clock, the only clock of the block |
| rst_ni | input | 1 | Asynchronous active-low reset |
| speed_i | input | 2 | Speed class: 00 single, 01 double, 10 quad, 11 unused |
| fast_i | input | 1 | 1 selects the higher master-clock multiple for the class |
| master_i | input | 1 | 1 when the converter drives the serial clocks |
| lrck_o | output | 1 | Frame clock, low for the left half |
| sclk_o | output | 1 | Bit clock, 64 periods per frame |
| frame_start_o | output | 1 | One-cycle pulse on the first cycle of each frame |
| err_o | output | 1 | Sticky illegal-setting flag |

## Verification
The bench builds the block with its default of 64 bit clocks per frame. That gives a 9-bit frame counter, which covers all six ratios from 64 to 512 master clocks per frame: the top counter bit is used at 512, and the dual-edge bit-clock path is used at 64. A reference model in the bench follows every cycle, sampling once in the high phase and once in the low phase of the master clock. This lets the master-clock-rate bit clock be checked at 64x. Settings are switched in the middle of a frame, into and out of the 64x ratio, to exercise boundary-only adoption. Both illegal settings are applied, and the error flag is shown to stay set after the inputs are corrected.

// File: rtl/audio_mclk_div_pkg.sv
`timescale 1ns/1ps
package audio_mclk_div_pkg;

   typedef enum logic [1:0] {
      SPD_SINGLE = 2'b00,
      SPD_DOUBLE = 2'b01,
      SPD_QUAD   = 2'b10,
      SPD_UNUSED = 2'b11
   } speed_e;

   // extra octaves of master clock above the minimum ratio, per speed class
   function automatic int unsigned speed_octaves(input speed_e s);
      case (s)
         SPD_SINGLE: return 2;
         SPD_DOUBLE: return 1;
         default:    return 0;
      endcase
   endfunction

endpackage

// File: rtl/audio_mclk_div_cfg.sv
`timescale 1ns/1ps
module audio_mclk_div_cfg
   import audio_mclk_div_pkg::*;
#(
   parameter int LOG_FB = 6,
   parameter int LGW    = 4
) (
   input  logic [1:0]     speed_i,
   input  logic           fast_i,
   input  logic           master_i,
   output logic [LGW-1:0] lg_o,
   output logic           bad_o
);

   speed_e spd;

   always_comb begin
      spd   = speed_e'(speed_i);
      lg_o  = LGW'(LOG_FB) + LGW'(speed_octaves(spd)) + LGW'(fast_i);
      bad_o = 1'b0;
      case (spd)
         SPD_UNUSED: begin
            bad_o = 1'b1;
            lg_o  = LGW'(LOG_FB + 2);
         end
         SPD_QUAD: bad_o = !fast_i && !master_i;
         default:  bad_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/audio_mclk_div_ctr.sv
`timescale 1ns/1ps
module audio_mclk_div_ctr #(
   parameter int CNT_W  = 9,
   parameter int LGW    = 4,
   parameter int LG_RST = 6
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [LGW-1:0]   lg_next_i,
   input  logic             bad_next_i,
   output logic             run_o,
   output logic [CNT_W-1:0] cnt_o,
   output logic [LGW-1:0]   lg_o,
   output logic             err_o
);

   logic             start_q, run_q, err_q;
   logic [CNT_W-1:0] cnt_q, lim;
   logic [LGW-1:0]   lg_q;
   logic             last, load;

   // last count of the active frame length, 2**lg_q - 1
   always_comb begin
      for (int i = 0; i < CNT_W; i++) begin
         lim[i] = (LGW'(i) < lg_q);
      end
   end

   assign last = (cnt_q == lim);
   assign load = !start_q || (run_q && last);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         start_q <= 1'b0;
         run_q   <= 1'b0;
         err_q   <= 1'b0;
         cnt_q   <= '0;
         lg_q    <= LGW'(LG_RST);
      end else begin
         start_q <= 1'b1;
         if (load && !err_q) begin
            cnt_q <= '0;
            if (bad_next_i) begin
               err_q <= 1'b1;
               run_q <= 1'b0;
            end else begin
               run_q <= 1'b1;
               lg_q  <= lg_next_i;
            end
         end else if (run_q) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign run_o = run_q;
   assign cnt_o = cnt_q;
   assign lg_o  = lg_q;
   assign err_o = err_q;

   AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= lim); // R2
   AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start_q && run_q && !last) |=> $stable(lg_q)); // R6
   AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_q |=> (err_q && !run_q)); // R7

endmodule

// File: rtl/audio_mclk_div_out.sv
`timescale 1ns/1ps
module audio_mclk_div_out #(
   parameter int CNT_W  = 9,
   parameter int LGW    = 4,
   parameter int LOG_FB = 6
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             run_i,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [LGW-1:0]   lg_i,
   output logic             lrck_o,
   output logic             sclk_o,
   output logic             frame_start_o
);

   logic [CNT_W:0] lr_tap, sc_tap;
   logic           pos_q, neg_q, fine;

   assign lr_tap[0] = 1'b0;
   assign sc_tap[0] = 1'b0;

   for (genvar g = 1; g <= CNT_W; g++) begin : g_tap
      assign lr_tap[g] = cnt_i[g-1];
      if (g > LOG_FB) begin : g_sc
         assign sc_tap[g] = cnt_i[g-LOG_FB-1];
      end else begin : g_nosc
         assign sc_tap[g] = 1'b0;
      end
   end

   // dual-edge pair: pos_q ^ neg_q follows the master clock level
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pos_q <= 1'b0;
      else         pos_q <= !pos_q;
   end

   always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni) neg_q <= 1'b0;
      else         neg_q <= pos_q;
   end

   assign fine          = run_i && (lg_i == LGW'(LOG_FB));
   assign lrck_o        = run_i && lr_tap[lg_i];
   assign sclk_o        = fine ? !(pos_q ^ neg_q) : (run_i && sc_tap[lg_i]);
   assign frame_start_o = run_i && (cnt_i == '0);

   AST_FALL_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_i && $fell(lrck_o)) |-> frame_start_o); // R5
   AST_PULSE_LEFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      frame_start_o |=> !lrck_o); // R4

endmodule

// File: rtl/audio_mclk_div.sv
`timescale 1ns/1ps
module audio_mclk_div #(
   parameter int FRAME_BITS = 64
) (
   input  logic       mclk_i,
   input  logic       rst_ni,
   input  logic [1:0] speed_i,
   input  logic       fast_i,
   input  logic       master_i,
   output logic       lrck_o,
   output logic       sclk_o,
   output logic       frame_start_o,
   output logic       err_o
);

   localparam int LOG_FB = $clog2(FRAME_BITS);
   localparam int CNT_W  = LOG_FB + 3;
   localparam int LGW    = $clog2(CNT_W + 1);

   if (FRAME_BITS < 2 || (1 << LOG_FB) != FRAME_BITS) begin : g_chk_fb
      $error("FRAME_BITS must be a power of two of at least 2");
   end

   logic [LGW-1:0]   lg_next, lg_act;
   logic             bad_next, run;
   logic [CNT_W-1:0] cnt;

   audio_mclk_div_cfg #(.LOG_FB(LOG_FB), .LGW(LGW)) u_cfg (
      .speed_i (speed_i),
      .fast_i  (fast_i),
      .master_i(master_i),
      .lg_o    (lg_next),
      .bad_o   (bad_next)
   );

   audio_mclk_div_ctr #(.CNT_W(CNT_W), .LGW(LGW), .LG_RST(LOG_FB)) u_ctr (
      .clk_i     (mclk_i),
      .rst_ni    (rst_ni),
      .lg_next_i (lg_next),
      .bad_next_i(bad_next),
      .run_o     (run),
      .cnt_o     (cnt),
      .lg_o      (lg_act),
      .err_o     (err_o)
   );

   audio_mclk_div_out #(.CNT_W(CNT_W), .LGW(LGW), .LOG_FB(LOG_FB)) u_out (
      .clk_i        (mclk_i),
      .rst_ni       (rst_ni),
      .run_i        (run),
      .cnt_i        (cnt),
      .lg_i         (lg_act),
      .lrck_o       (lrck_o),
      .sclk_o       (sclk_o),
      .frame_start_o(frame_start_o)
   );

   AST_ERR_QUIET: assert property (@(posedge mclk_i) disable iff (!rst_ni)
      err_o |-> (!lrck_o && !frame_start_o)); // R7

endmodule

// File: tb/audio_mclk_div_tb.sv
`timescale 1ns/100ps
module audio_mclk_div_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] speed = 2'b00;
   logic       fast = 1'b0;
   logic       master = 1'b1;
   logic       lrck, sclk, fs, err;

   int total = 0;
   int bad = 0;
   int pulses = 0;
   bit done = 1'b0;

   // reference model state
   bit m_started, m_run, m_err;
   int m_cnt, m_len;

   always #2.5 clk = ~clk;

   audio_mclk_div u_dut (
      .mclk_i       (clk),
      .rst_ni       (rst_n),
      .speed_i      (speed),
      .fast_i       (fast),
      .master_i     (master),
      .lrck_o       (lrck),
      .sclk_o       (sclk),
      .frame_start_o(fs),
      .err_o        (err)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int frame_len(input logic [1:0] s, input logic f);
      int oct;
      oct = (s == 2'b00) ? 2 : (s == 2'b01) ? 1 : 0;
      return 64 << (oct + int'(f));
   endfunction

   function automatic bit illegal(input logic [1:0] s, input logic f, input logic m);
      return (s == 2'b11) || (s == 2'b10 && !f && !m);
   endfunction

   task automatic do_reset();
      rst_n = 1'b0;
      m_started = 0; m_run = 0; m_err = 0; m_cnt = 0; m_len = 64;
      repeat (4) begin
         @(posedge clk);
         #1;
         chk(lrck == 0, "R1 lrck in reset", lrck, 0);
         chk(sclk == 0, "R1 sclk in reset", sclk, 0);
         chk(fs == 0,   "R1 frame_start in reset", fs, 0);
         chk(err == 0,  "R1 err in reset", err, 0);
      end
      #2;
      rst_n = 1'b1;
   endtask

   task automatic step(input int n, input string sc);
      for (int k = 0; k < n; k++) begin
         bit e_lr, e_sh, e_sl, e_fs;
         int d;
         @(posedge clk);
         if ((!m_started || (m_run && m_cnt == m_len - 1)) && !m_err) begin
            m_started = 1;
            m_cnt = 0;
            if (illegal(speed, fast, master)) begin
               m_err = 1;
               m_run = 0;
            end else begin
               m_run = 1;
               m_len = frame_len(speed, fast);
            end
         end else begin
            m_started = 1;
            if (m_run) m_cnt++;
         end
         d    = m_len / 64;
         e_lr = m_run && (m_cnt >= m_len / 2);
         e_fs = m_run && (m_cnt == 0);
         e_sh = m_run && (d >= 2) && ((m_cnt % d) >= d / 2);
         e_sl = m_run && ((d == 1) ? 1'b1 : e_sh);
         #1;
         chk(lrck == e_lr, {"R2 R4 lrck high phase ", sc}, lrck, e_lr);
         chk(sclk == e_sh, {"R3 sclk high phase ", sc}, sclk, e_sh);
         chk(fs == e_fs,   {"R5 frame_start ", sc}, fs, e_fs);
         chk(err == m_err, {"R7 R8 err ", sc}, err, m_err);
         if (fs) pulses++;
         #2.5;
         chk(lrck == e_lr, {"R2 R4 lrck low phase ", sc}, lrck, e_lr);
         chk(sclk == e_sl, {"R3 sclk low phase ", sc}, sclk, e_sl);
      end
   endtask

   task automatic run_mode(input logic [1:0] s, input logic f, input logic m,
                           input int frames, input string sc);
      speed = s; fast = f; master = m;
      do_reset();
      pulses = 0;
      step(frames * frame_len(s, f), sc);
      chk(pulses == frames, {"R2 R5 frames counted ", sc}, pulses, frames);
   endtask

   task automatic t_reset();
      do_reset();
      step(3, "R1 start after release");
   endtask

   task automatic t_change();
      speed = 2'b00; fast = 1'b0; master = 1'b1;
      do_reset();
      step(100, "R6 before change");
      speed = 2'b01; fast = 1'b1;
      step(156 + 2 * 256, "R6 to double fast");
      speed = 2'b10; fast = 1'b0;
      step(40, "R6 pending 64x");
      speed = 2'b00; fast = 1'b1;
      step(216 + 64, "R6 64x frame then single fast");
      step(512, "R6 single fast");
   endtask

   task automatic t_slave_err();
      run_mode(2'b10, 1'b0, 1'b0, 0, "R7 quad 64x slave");
      step(50, "R7 quiet");
      speed = 2'b00; fast = 1'b0; master = 1'b1;
      step(300, "R7 sticky after legal inputs");
      chk(err == 1, "R7 err still set", err, 1);
      run_mode(2'b00, 1'b0, 1'b1, 1, "R7 cleared by reset");
   endtask

   task automatic t_unused();
      run_mode(2'b11, 1'b0, 1'b1, 0, "R8 unused speed");
      step(100, "R8 quiet");
      chk(err == 1, "R8 err set", err, 1);
   endtask

   task automatic t_mid_err();
      speed = 2'b01; fast = 1'b0; master = 1'b0;
      do_reset();
      step(30, "R7 legal start");
      speed = 2'b10; fast = 1'b0;
      step(98 + 60, "R7 error at frame boundary");
   endtask

   initial begin
      t_reset();
      run_mode(2'b00, 1'b0, 1'b1, 2, "R2 single 256");
      run_mode(2'b00, 1'b1, 1'b1, 1, "R2 single 512");
      run_mode(2'b01, 1'b0, 1'b1, 2, "R2 double 128");
      run_mode(2'b01, 1'b1, 1'b0, 1, "R2 double 256");
      run_mode(2'b10, 1'b1, 1'b0, 2, "R2 quad 128");
      run_mode(2'b10, 1'b0, 1'b1, 3, "R9 quad 64x master");
      t_change();
      t_slave_err();
      t_unused();
      t_mid_err();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #500000;
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule